// File: doc/BRIEF.md
# Vectored Interrupt Priority Core

This block is the acceptance and prioritisation heart of a per-processor interrupt controller with 256 vectors. Each vector has three state bits: requested, in service, and level-triggered. A larger vector number outranks a smaller one. Vectors are grouped into priority classes of sixteen by their upper four bits.

A source posts a vector with its trigger kind. The block compares the best waiting request against the processor priority and raises a pending line to the CPU. The processor priority is built from the task priority and the class of the best vector in service. The CPU acknowledges the interrupt and receives the vector one cycle later. It signals completion with an end-of-interrupt pulse, which retires the best in-service vector. A task-priority register and a spurious-vector register tune the behaviour. The spurious-vector register holds a software-enable bit and the vector returned for acknowledges that are suppressed.

A peek port gives read access to the three state bits of any one vector, so the surrounding register decode can present them.

Top module: `vipc_core`

## Requirements
- R1: After reset, all request, in-service and trigger bits are 0, the task priority is 0, the spurious-vector register is 0x0FF (enable bit 8 clear), the processor priority is 0 and `irq_pending` is low.
- R2: A cycle with `acc_valid` high sets request bit `acc_vector`. It also writes `acc_level` into that vector's trigger bit: 1 means level, 0 means edge. Both are visible from the next cycle.
- R3: `ppr` equals the task priority when the task priority's bits 7:4 are at least the class (bits 7:4) of the highest in-service vector. Otherwise it equals that class followed by four zero bits. An empty in-service set counts as class 0.
- R4: `irq_pending` is high only when enable bit 8 of the spurious-vector register is set and some request exists. In addition, either `ppr` is 0 or the class of the highest request is strictly greater than the class of `ppr`.
- R5: When an acknowledge is granted, the cycle after `ack_req` shows `ack_valid` high with `ack_spurious` and `ack_empty` low and `ack_vector` set to the highest request. That vector's request bit is cleared and its in-service bit is set.
- R6: If the task priority is nonzero and the highest request is less than or equal to it as a full 8-bit value, an acknowledge returns bits 7:0 of the spurious-vector register with `ack_spurious` high. The request and in-service bits stay unchanged.
- R7: An acknowledge with no request, or while enable bit 8 is clear, returns `ack_empty` high with `ack_vector` 0 and changes no state.
- R8: `eoi` clears only the highest set in-service bit. When the in-service set is empty it changes nothing.
- R9: A write to the spurious-vector register keeps only bits 8:0 of `svr_wdata`. A write to the task priority loads all 8 bits.
- R10: With several requests waiting, successive granted acknowledges return them in strictly descending vector order, including vectors 255 and 0.
- R11: When an accept and a granted acknowledge occur in the same cycle, the acknowledge takes the previous highest request and the accepted vector is still recorded as requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Post a vector this cycle |
| acc_vector | input | 8 | Vector being posted |
| acc_level | input | 1 | Trigger kind of posted vector (1 level, 0 edge) |
| ack_req | input | 1 | CPU acknowledge |
| eoi | input | 1 | End-of-interrupt pulse |
| tpr_wr | input | 1 | Load task priority |
| tpr_wdata | input | 8 | Task priority value |
| svr_wr | input | 1 | Load spurious-vector register |
| svr_wdata | input | 16 | Spurious-vector write data (bits 8:0 kept) |
| peek_idx | input | 8 | Vector selected on the peek port |
| irq_pending | output | 1 | Interrupt pending to the CPU |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_vector | output | 8 | Vector returned for the acknowledge |
| ack_spurious | output | 1 | Result is the spurious vector |
| ack_empty | output | 1 | Nothing deliverable at acknowledge |
| ppr | output | 8 | Processor priority |
| svr_q | output | 9 | Spurious-vector register contents |
| tpr_q | output | 8 | Task priority register contents |
| peek_req | output | 1 | Request bit of `peek_idx` |
| peek_srv | output | 1 | In-service bit of `peek_idx` |
| peek_lvl | output | 1 | Trigger bit of `peek_idx` |

## Verification
The embedded properties check on every cycle several invariants. An accepted vector must be recorded with its trigger kind, and a granted acknowledge must move its vector into service. An end-of-interrupt must retire the top in-service bit, or nothing when the set is empty. The processor priority never drops below the task priority, the pending line never rises while software-disabled, and every acknowledge is answered the next cycle. What the properties cannot show is the ordering of results across a sequence. The scenarios cover descending delivery order, class comparison at equal and adjacent classes, spurious suppression at the exact task-priority boundary, and the same-cycle accept-with-acknowledge case. Each is checked against values derived from the requirements alone.

// File: rtl/vipc_pkg.sv
package vipc_pkg;
   // outcome of one acknowledge cycle
   typedef enum logic [1:0] {
      VK_IDLE = 2'd0,
      VK_TAKE = 2'd1,
      VK_SPUR = 2'd2,
      VK_NONE = 2'd3
   } vipc_ack_e;
endpackage

// File: rtl/vipc_prio_enc.sv
// Highest-set-bit finder; GROUP=0 selects a flat scan, otherwise a two-level
// group/bit search with GROUP bits per group.
module vipc_prio_enc #(
   parameter int N     = 256,
   parameter int GROUP = 32,
   localparam int IW   = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] top
);
   initial begin
      assert (N >= 2 && (N & (N - 1)) == 0)
         else $error("vipc_prio_enc: N must be a power of two");
      assert (GROUP == 0 || (N % GROUP == 0 && GROUP >= 2 && N / GROUP >= 2))
         else $error("vipc_prio_enc: GROUP must divide N into >=2 groups");
   end

   assign any = |vec;

   if (GROUP == 0) begin : g_flat
      always_comb begin
         top = '0;
         for (int i = 0; i < N; i++)
            if (vec[i]) top = IW'(i);
      end
   end else begin : g_two_level
      localparam int NG  = N / GROUP;
      localparam int GIW = $clog2(NG);
      localparam int BIW = $clog2(GROUP);
      logic [NG-1:0]    grp_any;
      logic [GIW-1:0]   grp_top;
      logic [GROUP-1:0] grp_bits;
      logic [BIW-1:0]   bit_top;

      for (genvar g = 0; g < NG; g++) begin : g_grp
         assign grp_any[g] = |vec[g*GROUP +: GROUP];
      end

      always_comb begin
         grp_top = '0;
         for (int g = 0; g < NG; g++)
            if (grp_any[g]) grp_top = GIW'(g);
         grp_bits = vec[grp_top*GROUP +: GROUP];
         bit_top  = '0;
         for (int b = 0; b < GROUP; b++)
            if (grp_bits[b]) bit_top = BIW'(b);
      end
      assign top = {grp_top, bit_top};
   end
endmodule

// File: rtl/vipc_vec_state.sv
// Request, in-service and trigger bit arrays with their update rules.
module vipc_vec_state #(
   parameter int N  = 256,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_valid,
   input  logic [IW-1:0] acc_vec,
   input  logic          acc_level,
   input  logic          ack_take,
   input  logic          eoi,
   input  logic          irr_any,
   input  logic [IW-1:0] irr_top,
   input  logic          isr_any,
   input  logic [IW-1:0] isr_top,
   output logic [N-1:0]  irr,
   output logic [N-1:0]  isr,
   output logic [N-1:0]  tmr
);
   logic [N-1:0] irr_n, isr_n, tmr_n;

   always_comb begin
      irr_n = irr;
      isr_n = isr;
      tmr_n = tmr;
      // retire first, then grant, then record the new arrival
      if (eoi && isr_any)     isr_n[isr_top] = 1'b0;
      if (ack_take && irr_any) begin
         irr_n[irr_top] = 1'b0;
         isr_n[irr_top] = 1'b1;
      end
      if (acc_valid) begin
         irr_n[acc_vec] = 1'b1;
         tmr_n[acc_vec] = acc_level;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr <= '0;
         isr <= '0;
         tmr <= '0;
      end else begin
         irr <= irr_n;
         isr <= isr_n;
         tmr <= tmr_n;
      end
   end

   AST_ACC_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> irr[$past(acc_vec)]);                                    // R11
   AST_ACC_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> tmr[$past(acc_vec)] == $past(acc_level));                // R2
   AST_GRANT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_take |=> isr[$past(irr_top)]);                                     // R5
   AST_EOI_RETIRES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && isr_any && !(ack_take && irr_top == isr_top)) |=> !isr[$past(isr_top)]); // R8
   AST_EOI_EMPTY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !isr_any && !ack_take) |=> $stable(isr));                      // R8
endmodule

// File: rtl/vipc_decide.sv
// Processor priority, pending decision and acknowledge outcome.
module vipc_decide
   import vipc_pkg::*;
#(
   parameter int VW   = 8,
   parameter int CLSW = 4,
   localparam int LOW = VW - CLSW
) (
   input  logic [VW-1:0] tpr,
   input  logic [VW:0]   svr,
   input  logic          irr_any,
   input  logic [VW-1:0] irr_top,
   input  logic          isr_any,
   input  logic [VW-1:0] isr_top,
   input  logic          ack_req,
   output logic [VW-1:0] ppr,
   output logic          pending,
   output vipc_ack_e     ack_kind
);
   initial begin
      assert (CLSW >= 1 && CLSW < VW)
         else $error("vipc_decide: class width must be below vector width");
   end

   logic            sw_en;
   logic [CLSW-1:0] tpr_cls, isr_cls, irr_cls, ppr_cls;

   assign sw_en   = svr[VW];
   assign tpr_cls = tpr[VW-1 -: CLSW];
   assign isr_cls = isr_any ? isr_top[VW-1 -: CLSW] : '0;
   assign irr_cls = irr_top[VW-1 -: CLSW];

   always_comb begin
      if (tpr_cls >= isr_cls) ppr = tpr;
      else                    ppr = {isr_cls, {LOW{1'b0}}};
   end
   assign ppr_cls = ppr[VW-1 -: CLSW];

   assign pending = sw_en && irr_any && ((ppr == '0) || (irr_cls > ppr_cls));

   always_comb begin
      if (!ack_req)                             ack_kind = VK_IDLE;
      else if (!sw_en || !irr_any)              ack_kind = VK_NONE;
      else if (tpr != '0 && irr_top <= tpr)     ack_kind = VK_SPUR;
      else                                      ack_kind = VK_TAKE;
   end
endmodule

// File: rtl/vipc_core.sv
module vipc_core
   import vipc_pkg::*;
#(
   parameter int NUM_VEC    = 256,
   parameter int CLASS_BITS = 4,
   parameter int SVR_IN_W   = 16,
   parameter int ENC_GROUP  = 32,
   localparam int VW        = $clog2(NUM_VEC)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_valid,
   input  logic [VW-1:0] acc_vector,
   input  logic          acc_level,
   input  logic          ack_req,
   input  logic          eoi,
   input  logic          tpr_wr,
   input  logic [VW-1:0] tpr_wdata,
   input  logic          svr_wr,
   input  logic [SVR_IN_W-1:0] svr_wdata,
   input  logic [VW-1:0] peek_idx,
   output logic          irq_pending,
   output logic          ack_valid,
   output logic [VW-1:0] ack_vector,
   output logic          ack_spurious,
   output logic          ack_empty,
   output logic [VW-1:0] ppr,
   output logic [VW:0]   svr_q,
   output logic [VW-1:0] tpr_q,
   output logic          peek_req,
   output logic          peek_srv,
   output logic          peek_lvl
);
   initial begin
      assert (SVR_IN_W >= VW + 1)
         else $error("vipc_core: spurious write port too narrow");
   end

   logic [NUM_VEC-1:0] irr, isr, tmr;
   logic               irr_any, isr_any;
   logic [VW-1:0]      irr_top, isr_top;
   vipc_ack_e          ack_kind;
   logic               ack_take;
   logic [SVR_IN_W-1:0] svr_unused;

   assign svr_unused = svr_wdata;
   assign ack_take   = (ack_kind == VK_TAKE);

   vipc_prio_enc #(.N(NUM_VEC), .GROUP(ENC_GROUP)) u_enc_req (
      .vec(irr), .any(irr_any), .top(irr_top));
   vipc_prio_enc #(.N(NUM_VEC), .GROUP(ENC_GROUP)) u_enc_srv (
      .vec(isr), .any(isr_any), .top(isr_top));

   vipc_vec_state #(.N(NUM_VEC)) u_state (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_vec(acc_vector), .acc_level(acc_level),
      .ack_take(ack_take), .eoi(eoi),
      .irr_any(irr_any), .irr_top(irr_top),
      .isr_any(isr_any), .isr_top(isr_top),
      .irr(irr), .isr(isr), .tmr(tmr));

   vipc_decide #(.VW(VW), .CLSW(CLASS_BITS)) u_decide (
      .tpr(tpr_q), .svr(svr_q),
      .irr_any(irr_any), .irr_top(irr_top),
      .isr_any(isr_any), .isr_top(isr_top),
      .ack_req(ack_req),
      .ppr(ppr), .pending(irq_pending), .ack_kind(ack_kind));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tpr_q        <= '0;
         svr_q        <= {1'b0, {VW{1'b1}}};
         ack_valid    <= 1'b0;
         ack_vector   <= '0;
         ack_spurious <= 1'b0;
         ack_empty    <= 1'b0;
      end else begin
         if (tpr_wr) tpr_q <= tpr_wdata;
         if (svr_wr) svr_q <= svr_unused[VW:0];
         ack_valid    <= (ack_kind != VK_IDLE);
         ack_spurious <= (ack_kind == VK_SPUR);
         ack_empty    <= (ack_kind == VK_NONE);
         case (ack_kind)
            VK_TAKE: ack_vector <= irr_top;
            VK_SPUR: ack_vector <= svr_q[VW-1:0];
            default: ack_vector <= '0;
         endcase
      end
   end

   assign peek_req = irr[peek_idx];
   assign peek_srv = isr[peek_idx];
   assign peek_lvl = tmr[peek_idx];

   AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      ppr >= tpr_q);                                                         // R3
   AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pending |-> svr_q[VW]);                                            // R4
   AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req |=> ack_valid);                                                // R5
   AST_ACK_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_spurious && ack_empty));                                         // R6
endmodule

// File: tb/tb_vipc_core.sv
module tb_vipc_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [7:0]  acc_vector = '0;
   logic        acc_level = 1'b0;
   logic        ack_req = 1'b0;
   logic        eoi = 1'b0;
   logic        tpr_wr = 1'b0;
   logic [7:0]  tpr_wdata = '0;
   logic        svr_wr = 1'b0;
   logic [15:0] svr_wdata = '0;
   logic [7:0]  peek_idx = '0;
   logic        irq_pending, ack_valid, ack_spurious, ack_empty;
   logic [7:0]  ack_vector, ppr, tpr_q;
   logic [8:0]  svr_q;
   logic        peek_req, peek_srv, peek_lvl;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // expected acknowledge results: kind 1 take, 2 spurious, 3 empty
   int    exp_kind_q[$];
   int    exp_vec_q[$];
   string exp_tag_q[$];

   vipc_core dut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_vector(acc_vector), .acc_level(acc_level),
      .ack_req(ack_req), .eoi(eoi),
      .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
      .svr_wr(svr_wr), .svr_wdata(svr_wdata),
      .peek_idx(peek_idx),
      .irq_pending(irq_pending), .ack_valid(ack_valid), .ack_vector(ack_vector),
      .ack_spurious(ack_spurious), .ack_empty(ack_empty), .ppr(ppr),
      .svr_q(svr_q), .tpr_q(tpr_q),
      .peek_req(peek_req), .peek_srv(peek_srv), .peek_lvl(peek_lvl));

   always #10 clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // monitor: pop expected acknowledge results
   always @(negedge clk) begin
      if (rst_n && ack_valid) begin
         if (exp_kind_q.size() == 0) begin
            check(1'b0, "ack-unexpected", int'(ack_vector), -1);
         end else begin
            int k, v;
            string t;
            int ak;
            k = exp_kind_q.pop_front();
            v = exp_vec_q.pop_front();
            t = exp_tag_q.pop_front();
            ak = ack_spurious ? 2 : (ack_empty ? 3 : 1);
            check(ak == k, {t, " kind"}, ak, k);
            check(int'(ack_vector) == v, {t, " vector"}, int'(ack_vector), v);
         end
      end
   end

   task automatic post(input logic [7:0] v, input logic lvl);
      @(negedge clk);
      acc_valid = 1'b1; acc_vector = v; acc_level = lvl;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic ack(input int kind, input int v, input string tag);
      @(negedge clk);
      ack_req = 1'b1;
      exp_kind_q.push_back(kind); exp_vec_q.push_back(v); exp_tag_q.push_back(tag);
      @(negedge clk);
      ack_req = 1'b0;
   endtask

   task automatic do_eoi();
      @(negedge clk); eoi = 1'b1;
      @(negedge clk); eoi = 1'b0;
   endtask

   task automatic set_tpr(input logic [7:0] v);
      @(negedge clk); tpr_wr = 1'b1; tpr_wdata = v;
      @(negedge clk); tpr_wr = 1'b0;
   endtask

   task automatic set_svr(input logic [15:0] v);
      @(negedge clk); svr_wr = 1'b1; svr_wdata = v;
      @(negedge clk); svr_wr = 1'b0;
   endtask

   task automatic peek(input logic [7:0] idx, input string tag,
                       input bit e_req, input bit e_srv, input bit e_lvl);
      peek_idx = idx;
      #1;
      check(peek_req == e_req, {tag, " req bit"}, int'(peek_req), int'(e_req));
      check(peek_srv == e_srv, {tag, " srv bit"}, int'(peek_srv), int'(e_srv));
      check(peek_lvl == e_lvl, {tag, " lvl bit"}, int'(peek_lvl), int'(e_lvl));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=0x1 expected=0x0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(irq_pending == 1'b0, "R1 pending", int'(irq_pending), 0);
      check(ppr == 8'h00, "R1 ppr", int'(ppr), 0);
      check(svr_q == 9'h0FF, "R1 svr", int'(svr_q), 'h0FF);
      check(tpr_q == 8'h00, "R1 tpr", int'(tpr_q), 0);
      peek(8'd0, "R1 v0", 0, 0, 0);
      peek(8'd255, "R1 v255", 0, 0, 0);

      // R2 edge post while disabled; R4 no pending; R7 ack while disabled
      post(8'h45, 1'b0);
      peek(8'h45, "R2 edge", 1, 0, 0);
      check(irq_pending == 1'b0, "R4 disabled", int'(irq_pending), 0);
      ack(3, 0, "R7 disabled");
      peek(8'h45, "R7 unchanged", 1, 0, 0);

      // R9 enable, only bits 8:0 kept
      set_svr(16'hFFFF);
      check(svr_q == 9'h1FF, "R9 svr mask", int'(svr_q), 'h1FF);
      check(irq_pending == 1'b1, "R4 enabled", int'(irq_pending), 1);

      post(8'h80, 1'b1);
      peek(8'h80, "R2 level", 1, 0, 1);
      post(8'h21, 1'b0);

      // R5/R10 highest first
      ack(1, 'h80, "R5 take top");
      @(negedge clk);
      peek(8'h80, "R5 moved", 0, 1, 1);
      check(ppr == 8'h80, "R3 isr class wins", int'(ppr), 'h80);
      check(irq_pending == 1'b0, "R4 class not above", int'(irq_pending), 0);
      ack(1, 'h45, "R10 second");
      // R8 EOI retires highest in service
      do_eoi();
      peek(8'h80, "R8 top retired", 0, 0, 1);
      peek(8'h45, "R8 lower kept", 0, 1, 0);
      check(ppr == 8'h40, "R3 after eoi", int'(ppr), 'h40);
      check(irq_pending == 1'b0, "R4 class 2 vs 4", int'(irq_pending), 0);
      do_eoi();
      check(ppr == 8'h00, "R3 empty isr", int'(ppr), 0);
      check(irq_pending == 1'b1, "R4 ppr zero", int'(irq_pending), 1);

      // R6 spurious suppression at and around the boundary
      set_tpr(8'h35);
      check(tpr_q == 8'h35, "R9 tpr load", int'(tpr_q), 'h35);
      check(ppr == 8'h35, "R3 tpr wins", int'(ppr), 'h35);
      check(irq_pending == 1'b0, "R4 tpr class", int'(irq_pending), 0);
      ack(2, 'hFF, "R6 below tpr");
      @(negedge clk);
      peek(8'h21, "R6 unchanged", 1, 0, 0);
      set_tpr(8'h21);
      ack(2, 'hFF, "R6 equal tpr");
      set_tpr(8'h20);
      ack(1, 'h21, "R6 just above");
      @(negedge clk);
      check(ppr == 8'h20, "R3 equal class tpr", int'(ppr), 'h20);
      do_eoi();

      // R8 eoi with empty in-service set
      post(8'h90, 1'b0);
      do_eoi();
      peek(8'h90, "R8 empty nop", 1, 0, 0);
      check(ppr == 8'h20, "R8 ppr kept", int'(ppr), 'h20);

      // R11 accept together with a granted acknowledge
      @(negedge clk);
      acc_valid = 1'b1; acc_vector = 8'h10; acc_level = 1'b1; ack_req = 1'b1;
      exp_kind_q.push_back(1); exp_vec_q.push_back('h90); exp_tag_q.push_back("R11 ack");
      @(negedge clk);
      acc_valid = 1'b0; ack_req = 1'b0;
      peek(8'h10, "R11 recorded", 1, 0, 1);
      peek(8'h90, "R11 granted", 0, 1, 0);
      do_eoi();
      set_tpr(8'h00);
      ack(1, 'h10, "R5 low vector");
      do_eoi();
      ack(3, 0, "R7 nothing requested");

      // R10 extremes
      post(8'h00, 1'b0);
      post(8'hFF, 1'b0);
      ack(1, 'hFF, "R10 vector 255");
      ack(1, 'h00, "R10 vector 0");
      do_eoi();
      do_eoi();
      peek(8'hFF, "R10 retired 255", 0, 0, 0);

      // R9 low byte is the spurious vector; enable clear disables
      set_svr(16'hFEA5);
      check(svr_q == 9'h0A5, "R9 svr low bits", int'(svr_q), 'h0A5);
      post(8'h33, 1'b0);
      check(irq_pending == 1'b0, "R4 disabled again", int'(irq_pending), 0);
      ack(3, 0, "R7 disabled again");

      repeat (3) @(negedge clk);
      check(exp_kind_q.size() == 0, "scoreboard drained", exp_kind_q.size(), 0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule